// File: doc/BRIEF.md
# Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit characters over a single data-out line and a single data-in line, both timed by one shared serial clock. The least significant bit goes first, and every character has exactly eight data bits. The serial clock comes from one of two sources. It can come from an internal divider, in which case the block drives the clock pin. It can also come from an external pin, which the block synchronizes to the system clock and then edge-detects.

Each direction has a holding register and a shift register, so characters can run back to back.
- **Transmit side.** It takes bytes over a valid/ready handshake. A byte is transferred in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while transmit is enabled and the holding register is empty. A source holding `tx_valid` with `tx_ready` low must keep `tx_data` stable until the transfer happens.
- **Receive side.** It offers each completed byte with `rx_valid`. The byte is consumed in a cycle where `rx_valid` and `rx_ready` are both high. `rx_data` stays fixed while `rx_valid` is high and unread.
- **Back-pressure on receive.** A character that finishes while the previous byte is still unread is dropped, and the block raises a sticky `overrun` flag.

Top module: `ssio_xcvr`

## Requirements
- R1: A character is 8 data bits sent least significant bit first on `sd_out`, with no extra framing bits. It is received the same way on `sd_in`, so `rx_data[0]` is the first bit that arrives.
- R2: `sd_out` changes only just after a falling serial clock edge. `sd_in` is sampled on rising serial clock edges.
- R3: After the eighth bit of a character, `sd_out` keeps the level of bit 7 until the next character starts.
- R4: With the internal clock selected (`clk_ext_sel`=0), the following hold:
  - `sck_oe` is 1.
  - `sck_out` idles high.
  - A transmitted character produces exactly 8 pulses.
  - Each clock half-period lasts `divisor`+2 system clock cycles.
- R5: With the internal clock selected and receive enabled, the clock runs continuously. It stops at a character boundary once `overrun` is set, or after the current pulse once `rx_en` is cleared.
- R6: With the external clock selected (`clk_ext_sel`=1), the following hold:
  - `sck_oe` is 0.
  - The block shifts on edges of `sck_in`, which is synchronized through two flip-flops and then edge-detected.
- R7: A byte written while the shifter is idle moves into it immediately, and `tx_empty` returns to 1. A byte written during a shift waits in the holding register. It starts right after the eighth bit, with no idle clock half-period between the two characters.
- R8: `rx_valid` and `rx_data` hold until read with `rx_ready`. A byte may be read while the next character is still shifting in.
- R9: Clearing `tx_en` sets `tx_empty` to 1 on the next cycle and drops any pending byte. While `tx_en` is 0, `tx_ready` is 0 and `tx_valid` has no effect.
- R10: Clearing `rx_en` leaves `rx_valid`, `overrun` and `rx_data` unchanged.
- R11: A character that completes while `rx_valid` is 1 and unread is handled as follows:
  - The character is discarded and `rx_data` keeps its old value.
  - `overrun` is set.
  - While `overrun` is set, the receiver ignores serial clock edges.
  - `overrun_clr` clears the flag.
- R12: Transmit and receive run together on the same clock edges, so a byte can go out and a byte come in during the same 8 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_ext_sel | input | 1 | 0: internal divider clock, 1: external clock on `sck_in` |
| divisor | input | 8 | Internal clock half-period is divisor+2 system cycles |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmit holding register accepts a byte |
| tx_empty | output | 1 | Transmit holding register is empty |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Receive holding register is full |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Clears `overrun` |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internal serial clock output |
| sck_oe | output | 1 | Clock pin output enable |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |

## Verification
Several properties are checked on every cycle:
- `sd_out` moves only right after a falling strobe.
- The two edge strobes never coincide.
- An unread receive byte and its valid flag stay frozen.
- `overrun` persists until cleared.
- `rx_data` cannot change while receive is disabled.
- Disabling transmit empties the holding register on the next cycle.

Some behaviours need whole transfers and can only be shown by the directed scenarios:
- the bit order and MSB hold level;
- the exact pulse count and half-period length;
- back-to-back reload with no gap;
- the free-running receive clock stopping at overrun;
- discarding characters during overrun;
- full-duplex exchange under an external clock.

// File: rtl/ssio_pkg.sv
package ssio_pkg;
  typedef enum logic {
    CLK_INTERNAL = 1'b0,
    CLK_EXTERNAL = 1'b1
  } clk_src_e;

  localparam int CHAR_BITS = 8;
endpackage

// File: rtl/ssio_clkgen.sv
module ssio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ssio_pkg::clk_src_e  src,
  input  logic [DIV_W-1:0]    divisor,
  input  logic                run,
  input  logic                sck_in,
  output logic                sck_out,
  output logic                sck_oe,
  output logic                fall_stb,
  output logic                rise_stb
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] hcnt;
  logic [CNT_W-1:0] limit;
  logic             sck_q, fall_q, rise_q;
  logic [2:0]       sync_q;
  logic             ext_fall, ext_rise;

  assign limit = {1'b0, divisor} + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt   <= '1;
      sck_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      if (src == ssio_pkg::CLK_EXTERNAL) begin
        sck_q <= 1'b1;
        hcnt  <= '1;
      end else if (!sck_q) begin
        if (hcnt >= limit) begin
          sck_q  <= 1'b1;
          rise_q <= 1'b1;
          hcnt   <= '0;
        end else begin
          hcnt <= hcnt + CNT_W'(1);
        end
      end else if (hcnt >= limit) begin
        if (run) begin
          sck_q  <= 1'b0;
          fall_q <= 1'b1;
          hcnt   <= '0;
        end
      end else begin
        hcnt <= hcnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], sck_in};
  end

  assign ext_fall = sync_q[2] & ~sync_q[1];
  assign ext_rise = ~sync_q[2] & sync_q[1];

  assign fall_stb = (src == ssio_pkg::CLK_EXTERNAL) ? ext_fall : fall_q;
  assign rise_stb = (src == ssio_pkg::CLK_EXTERNAL) ? ext_rise : rise_q;
  assign sck_out  = sck_q;
  assign sck_oe   = (src == ssio_pkg::CLK_INTERNAL);
endmodule

// File: rtl/ssio_tx.sv
module ssio_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         fall_stb,
  input  logic         rise_stb,
  output logic         empty,
  output logic         active,
  output logic         sd_out
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  hold, shreg;
  logic          hold_full, busy, sd_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      shreg     <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      sd_q      <= 1'b1;
    end else if (!en) begin
      hold_full <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
    end else begin
      if (busy) begin
        if (fall_stb && cnt != CW'(W)) begin
          sd_q  <= shreg[0];
          shreg <= shreg >> 1;
          cnt   <= cnt + CW'(1);
        end else if (rise_stb && cnt == CW'(W)) begin
          if (hold_full) begin
            shreg     <= hold;
            hold_full <= 1'b0;
            cnt       <= '0;
          end else begin
            busy <= 1'b0;
          end
        end
      end else if (hold_full) begin
        shreg     <= hold;
        hold_full <= 1'b0;
        busy      <= 1'b1;
        cnt       <= '0;
      end
      if (wr_valid && !hold_full) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  assign empty  = ~hold_full;
  assign active = busy | hold_full;
  assign sd_out = sd_q;
endmodule

// File: rtl/ssio_rx.sv
module ssio_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         rise_stb,
  input  logic         sd_in,
  input  logic         rd,
  input  logic         ovr_clr,
  output logic         full,
  output logic         ovr,
  output logic [W-1:0] data
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  shreg;
  logic [W-1:0]  next_sh;
  logic [CW-1:0] cnt;

  assign next_sh = {sd_in, shreg[W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      data  <= '0;
      cnt   <= '0;
      full  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (rd)      full <= 1'b0;
      if (ovr_clr) ovr  <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (rise_stb && !ovr) begin
        shreg <= next_sh;
        if (cnt == CW'(W - 1)) begin
          cnt <= '0;
          if (full && !rd) begin
            ovr <= 1'b1;
          end else begin
            data <= next_sh;
            full <= 1'b1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ssio_xcvr.sv
module ssio_xcvr #(
  parameter int DATA_W = ssio_pkg::CHAR_BITS,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_ext_sel,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              overrun,
  input  logic              overrun_clr,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sd_in,
  output logic              sd_out
);
  ssio_pkg::clk_src_e src;
  logic fall_stb, rise_stb, tx_active, gen_run, rd_fire;

  assign src      = ssio_pkg::clk_src_e'(clk_ext_sel);
  assign tx_ready = tx_en & tx_empty;
  assign rd_fire  = rx_valid & rx_ready;
  assign gen_run  = tx_active | (rx_en & ~overrun);

  ssio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .divisor  (divisor),
    .run      (gen_run),
    .sck_in   (sck_in),
    .sck_out  (sck_out),
    .sck_oe   (sck_oe),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb)
  );

  ssio_tx #(.W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tx_en),
    .wr_valid (tx_valid & tx_ready),
    .wr_data  (tx_data),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .empty    (tx_empty),
    .active   (tx_active),
    .sd_out   (sd_out)
  );

  ssio_rx #(.W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .rise_stb (rise_stb),
    .sd_in    (sd_in),
    .rd       (rd_fire),
    .ovr_clr  (overrun_clr),
    .full     (rx_valid),
    .ovr      (overrun),
    .data     (rx_data)
  );
endmodule

// File: rtl/ssio_xcvr_chk.sv
module ssio_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_empty,
  input logic              sd_out,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              overrun,
  input logic              overrun_clr,
  input logic              fall_stb,
  input logic              rise_stb
);
  // R2: the data line moves only in the cycle after a falling strobe
  assert_line_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_out) |-> $past(fall_stb));

  // R2: rising and falling strobes never fire together
  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb}));

  assert_empty_on_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_empty);

  assert_unread_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !overrun_clr) |=> overrun);

  assert_rx_frozen_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(rx_data));
endmodule

bind ssio_xcvr ssio_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .tx_empty    (tx_empty),
  .sd_out      (sd_out),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .overrun     (overrun),
  .overrun_clr (overrun_clr),
  .fall_stb    (fall_stb),
  .rise_stb    (rise_stb)
);

// File: tb/tb_ssio_xcvr.sv
module tb_ssio_xcvr;
  localparam int DIVISOR  = 3;
  localparam int HALF     = DIVISOR + 2;
  localparam int EXT_HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_ext_sel = 1'b0;
  logic [7:0] divisor = 8'(DIVISOR);
  logic       tx_en = 1'b0, rx_en = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_empty;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       overrun;
  logic       overrun_clr = 1'b0;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe;
  logic       sd_in = 1'b1;
  logic       sd_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ssio_xcvr dut (
    .clk(clk), .rst_n(rst_n), .clk_ext_sel(clk_ext_sel), .divisor(divisor),
    .tx_en(tx_en), .rx_en(rx_en), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .overrun(overrun),
    .overrun_clr(overrun_clr), .sck_in(sck_in), .sck_out(sck_out),
    .sck_oe(sck_oe), .sd_in(sd_in), .sd_out(sd_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic read_byte();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  // Watch the internal clock pin: capture data at rising edges, count pulses,
  // longest high run between pulses, and data changes while the clock is high.
  task automatic capture_int(input int cycles, output logic [15:0] bits,
                             output int nbits, output int max_gap,
                             output int high_moves);
    logic prev_sck = sck_out;
    logic prev_sd  = sd_out;
    int   run      = 0;
    bits = '0; nbits = 0; max_gap = 0; high_moves = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (sck_out && sd_out != prev_sd) high_moves++;
      if (!prev_sck && sck_out) begin
        if (nbits < 16) bits[nbits] = sd_out;
        nbits++;
      end
      if (prev_sck && !sck_out && nbits > 0 && run > max_gap) max_gap = run;
      run      = sck_out ? run + 1 : 0;
      prev_sck = sck_out;
      prev_sd  = sd_out;
    end
  endtask

  task automatic count_falls(input int cycles, output int falls);
    logic prev = sck_out;
    falls = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (prev && !sck_out) falls++;
      prev = sck_out;
    end
  endtask

  // Act as an external master: drive one character in, sample sd_out before each rise.
  task automatic ext_xfer(input logic [7:0] din, output logic [7:0] dout);
    dout = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sck_in = 1'b0;
      sd_in  = din[i];
      repeat (EXT_HALF) @(negedge clk);
      dout[i] = sd_out;
      sck_in  = 1'b1;
      repeat (EXT_HALF) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9", "tx_empty after reset", tx_empty, 1);
    chk("R8", "rx_valid after reset", rx_valid, 0);
    chk("R11", "overrun after reset", overrun, 0);
    chk("R4", "sck_out idle level", sck_out, 1);
    chk("R4", "sck_oe internal", sck_oe, 1);
    chk("R3", "sd_out reset level", sd_out, 1);
  endtask

  task automatic t_tx_single(input logic [7:0] b);
    logic [15:0] bits; int n, gap, mv;
    write_byte(b);
    capture_int(200, bits, n, gap, mv);
    chk("R1", "tx bits LSB first", bits[7:0], b);
    chk("R4", "pulses per character", n, 8);
    chk("R4", "half period cycles", gap, HALF);
    chk("R2", "sd_out moves while sck high", mv, 0);
    chk("R3", "line holds MSB", sd_out, b[7]);
    chk("R4", "clock idles high", sck_out, 1);
  endtask

  task automatic t_tx_back_to_back();
    logic [15:0] bits; int n, gap, mv;
    write_byte(8'h3C);
    fork
      write_byte(8'hC3);
      capture_int(300, bits, n, gap, mv);
    join
    chk("R7", "two characters in order", bits, 16'hC33C);
    chk("R7", "pulse count back to back", n, 16);
    chk("R7", "no idle gap between characters", gap, HALF);
    chk("R3", "line holds MSB after pair", sd_out, 1);
  endtask

  task automatic t_tx_disable();
    int f;
    write_byte(8'h11);
    write_byte(8'h22);
    chk("R7", "second byte waits while busy", tx_empty, 0);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R9", "tx_empty after disable", tx_empty, 1);
    chk("R9", "tx_ready while disabled", tx_ready, 0);
    repeat (20) @(negedge clk);
    tx_data = 8'h55; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R9", "write ignored while disabled", tx_empty, 1);
    count_falls(100, f);
    chk("R9", "no pulses after disabled write", f, 0);
  endtask

  task automatic t_rx_external();
    logic [7:0] o;
    ext_xfer(8'h96, o);
    chk("R6", "sck_oe external", sck_oe, 0);
    chk("R6", "rx byte external", rx_data, 8'h96);
    chk("R8", "rx_valid set", rx_valid, 1);
    fork
      ext_xfer(8'h4B, o);
      begin repeat (40) @(negedge clk); read_byte(); end
    join
    chk("R8", "read during shift, new byte", rx_data, 8'h4B);
    chk("R8", "valid after second byte", rx_valid, 1);
    chk("R11", "no overrun when read in time", overrun, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] o;
    ext_xfer(8'hE1, o);
    chk("R11", "overrun set", overrun, 1);
    chk("R11", "old byte kept", rx_data, 8'h4B);
    ext_xfer(8'h0F, o);
    chk("R11", "ignored during overrun", rx_data, 8'h4B);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "rx_valid kept after rx disable", rx_valid, 1);
    chk("R10", "overrun kept after rx disable", overrun, 1);
    chk("R10", "rx_data kept after rx disable", rx_data, 8'h4B);
    rx_en = 1'b1;
    @(negedge clk); overrun_clr = 1'b1;
    @(negedge clk); overrun_clr = 1'b0;
    chk("R11", "overrun cleared", overrun, 0);
    read_byte();
    chk("R8", "valid cleared by read", rx_valid, 0);
    ext_xfer(8'h77, o);
    chk("R11", "receive resumes after clear", rx_data, 8'h77);
    read_byte();
  endtask

  task automatic t_full_duplex();
    logic [7:0] o;
    tx_en = 1'b1;
    write_byte(8'hD2);
    ext_xfer(8'h69, o);
    chk("R12", "byte out during duplex", o, 8'hD2);
    chk("R12", "byte in during duplex", rx_data, 8'h69);
    read_byte();
    tx_en = 1'b0;
  endtask

  task automatic t_rx_internal_run();
    int f;
    clk_ext_sel = 1'b0;
    sd_in = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    count_falls(600, f);
    chk("R5", "pulses until overrun", f, 16);
    chk("R5", "first byte kept", rx_data, 8'hFF);
    chk("R5", "overrun stops clock", overrun, 1);
    chk("R5", "clock parked high", sck_out, 1);
    overrun_clr = 1'b1; rx_ready = 1'b1;
    @(negedge clk);
    overrun_clr = 1'b0; rx_ready = 1'b0;
    repeat (30) @(negedge clk);
    rx_en = 1'b0;
    repeat (2 * HALF + 2) @(negedge clk);
    count_falls(100, f);
    chk("R5", "no pulses after rx disable", f, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    tx_en = 1'b1;
    t_tx_single(8'hA5);
    t_tx_single(8'h5A);
    t_tx_back_to_back();
    t_tx_disable();
    clk_ext_sel = 1'b1;
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    t_rx_external();
    t_overrun();
    t_full_duplex();
    rx_en = 1'b0;
    t_rx_internal_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule